// File: doc/BRIEF.md
# Subband 8-Point Inverse Transform Engine

This block rebuilds eight signed samples from eight signed transform coefficients. The coefficients are in the factored subband form: the forward transform first folds the samples with a ±1 butterfly matrix and then applies a block-diagonal orthonormal coefficient matrix. The engine undoes both factors in turn through their transposes. A bank of four multipliers runs for five cycles against a ten-entry constant table. Carry-save compression merges the products into an intermediate vector z. An accumulator array then folds z back through the transposed ±1 matrix. One final shift, with rounding and clamping, yields the samples.

A load is a single-cycle `start` pulse while the engine is idle, with all eight coefficients presented side by side. Eight cycles later the engine raises `done` for one cycle with all eight samples. The samples then hold until the next block finishes. The coefficient scale is unnormalized: it is the orthonormal scale times √8, so a block with only C0 set gives a flat output of C0/8. The final scale is therefore a plain arithmetic shift.

Top module: `idct8_subband`

## Requirements
- R1: After reset `done` is 0, every sample field of `samp_out` is 0 and the engine is idle.
- R2: When `start` is 1 on a clock edge while idle, the engine captures `coef_in` as eight signed CW-bit coefficients, with Ck at bits [k*CW +: CW], and begins a block.
- R3: `done` is 1 for exactly one cycle, right after the 8th clock edge following the capturing edge, and `samp_out` carries the new samples in that cycle.
- R4: The first two z entries pass straight through: z0 = C0·2^14 and z1 = C1·2^14.
- R5: The rotation pair uses Q14 constants A=15137 and B=6270: z2 = A·C2 − B·C3 and z3 = B·C2 + A·C3.
- R6: With Q14 constants P=14847, Q=6151, S=2952, T=1222, U=5213, V=12586, W=3483, Y=8410: z4 = P·C4 − S·C5 − U·C6 + W·C7; z5 = Q·C4 − T·C5 + V·C6 − Y·C7; z6 = S·C4 + P·C5 + W·C6 + U·C7; z7 = −T·C4 − Q·C5 + Y·C6 + V·C7.
- R7: Sample n (0..7, at bits [n*XW +: XW]) is floor((Σk s(k,n)·zk + 2^16) / 2^17). Here s(k,n) is −1 when the 3-bit reversal of k ANDed with n has odd parity, and +1 otherwise. A half step therefore rounds up.
- R8: A sample whose value under R7 lies outside [−2^(XW−1), 2^(XW−1)−1] is clamped to the nearer limit instead of wrapping.
- R9: A `start` pulse while a block is in progress is ignored. The running block's result is unchanged and no extra `done` follows.
- R10: A `start` in the cycle where `done` is 1 is accepted. The previous samples stay on `samp_out` until the new block's `done`.
- R11: A block produced from 12-bit samples by the forward factored transform (±1 fold, then the matrix whose transpose R5 and R6 give, rounded to integers) comes back within ±2 LSB of the original samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load request; taken only while idle |
| coef_in | input | 8*CW | Eight signed coefficients, Ck at [k*CW +: CW] |
| done | output | 1 | One-cycle strobe marking new samples |
| samp_out | output | 8*XW | Eight signed samples, sample n at [n*XW +: XW] |

## Verification
The completion of one block and the capture of the next can fall in the same cycle. The bench provokes this by driving `start` with a new coefficient set exactly in the cycle `done` is high. It then checks that the earlier samples stay on the output while the new block runs, and that the new block finishes eight edges after that cycle with its own values. A mid-block `start` with different coefficients is also issued, and the result is judged to match the first block alone.

// File: rtl/idct8_pkg.sv
`timescale 1ns/1ps
package idct8_pkg;

    localparam int FRAC = 14;
    localparam int KW   = 16;
    localparam int NK   = 10;

    typedef logic signed [KW-1:0] kcoef_t;

    // magnitudes in Q14; the sign is chosen by the schedule below
    localparam kcoef_t KROM [NK] = '{
        16'sd15137, 16'sd6270,  16'sd14847, 16'sd6151, 16'sd2952,
        16'sd1222,  16'sd5213,  16'sd12586, 16'sd3483, 16'sd8410
    };

    localparam int KA = 0, KB = 1, KP = 2, KQ = 3, KS = 4;
    localparam int KT = 5, KU = 6, KV = 7, KWW = 8, KY = 9;

    // constant fed to multiplier m during multiply step s
    function automatic kcoef_t step_const(input logic [2:0] s, input logic [1:0] m);
        case ({s, m})
            5'b000_00: return  KROM[KA];
            5'b000_01: return -KROM[KB];
            5'b000_10: return  KROM[KB];
            5'b000_11: return  KROM[KA];
            5'b001_00: return  KROM[KP];
            5'b001_01: return -KROM[KS];
            5'b001_10: return -KROM[KU];
            5'b001_11: return  KROM[KWW];
            5'b010_00: return  KROM[KQ];
            5'b010_01: return -KROM[KT];
            5'b010_10: return  KROM[KV];
            5'b010_11: return -KROM[KY];
            5'b011_00: return  KROM[KS];
            5'b011_01: return  KROM[KP];
            5'b011_10: return  KROM[KWW];
            5'b011_11: return  KROM[KU];
            5'b100_00: return -KROM[KT];
            5'b100_01: return -KROM[KQ];
            5'b100_10: return  KROM[KY];
            5'b100_11: return  KROM[KV];
            default:   return '0;
        endcase
    endfunction

    // coefficient index feeding multiplier m during step s
    function automatic logic [2:0] step_src(input logic [2:0] s, input logic [1:0] m);
        if (s == 3'd0) return m[0] ? 3'd3 : 3'd2;
        return 3'd4 + {1'b0, m};
    endfunction

    // 1 when butterfly term k enters sample n negated
    function automatic logic fold_neg(input logic [2:0] k, input logic [2:0] n);
        return ^({k[0], k[1], k[2]} & n);
    endfunction

endpackage

// File: rtl/idct8_mularray.sv
`timescale 1ns/1ps
module idct8_mularray #(
    parameter int CW = 18,
    parameter int KW = 16,
    parameter int NM = 4,
    localparam int PW = CW + KW
) (
    input  logic [NM-1:0][CW-1:0] op,
    input  logic [NM-1:0][KW-1:0] kc,
    output logic [NM-1:0][PW-1:0] prod
);
    for (genvar g = 0; g < NM; g++) begin : g_mul
        logic signed [PW-1:0] a_ext;
        logic signed [PW-1:0] b_ext;
        assign a_ext   = $signed({{KW{op[g][CW-1]}}, op[g]});
        assign b_ext   = $signed({{CW{kc[g][KW-1]}}, kc[g]});
        assign prod[g] = a_ext * b_ext;
    end
endmodule

// File: rtl/idct8_csa32.sv
`timescale 1ns/1ps
module idct8_csa32 #(
    parameter int W = 36
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] sum,
    output logic [W-1:0] cry
);
    logic [W-1:0] maj;
    assign sum = a ^ b ^ c;
    assign maj = (a & b) | (a & c) | (b & c);
    assign cry = {maj[W-2:0], 1'b0};
endmodule

// File: rtl/idct8_csa42.sv
`timescale 1ns/1ps
module idct8_csa42 #(
    parameter int W = 36
) (
    input  logic [3:0][W-1:0] term,
    output logic [W-1:0]      total
);
    logic [W-1:0] s1, c1, s2, c2;

    idct8_csa32 #(.W(W)) u_lvl1 (.a(term[0]), .b(term[1]), .c(term[2]), .sum(s1), .cry(c1));
    idct8_csa32 #(.W(W)) u_lvl2 (.a(s1),      .b(c1),      .c(term[3]), .sum(s2), .cry(c2));

    assign total = s2 + c2;
endmodule

// File: rtl/idct8_acc.sv
`timescale 1ns/1ps
module idct8_acc
    import idct8_pkg::*;
#(
    parameter int ZW = 36,
    parameter int AW = 39
) (
    input  logic [7:0][AW-1:0] base,
    input  logic [ZW-1:0]      za,
    input  logic [ZW-1:0]      zb,
    input  logic [2:0]         ka,
    input  logic [2:0]         kb,
    input  logic               use_b,
    output logic [7:0][AW-1:0] nxt
);
    localparam int XTRA = AW - ZW;

    logic [AW-1:0] za_e, zb_e;
    assign za_e = {{XTRA{za[ZW-1]}}, za};
    assign zb_e = use_b ? {{XTRA{zb[ZW-1]}}, zb} : '0;

    for (genvar n = 0; n < 8; n++) begin : g_lane
        logic [AW-1:0] ta, tb;
        assign ta = fold_neg(ka, 3'(n)) ? (~za_e + 1'b1) : za_e;
        assign tb = fold_neg(kb, 3'(n)) ? (~zb_e + 1'b1) : zb_e;
        assign nxt[n] = base[n] + ta + tb;
    end
endmodule

// File: rtl/idct8_subband.sv
`timescale 1ns/1ps
module idct8_subband
    import idct8_pkg::*;
#(
    parameter int CW = 18,
    parameter int XW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [8*CW-1:0] coef_in,
    output logic            done,
    output logic [8*XW-1:0] samp_out
);
    localparam int PW = CW + KW;
    localparam int ZW = PW + 2;
    localparam int AW = ZW + 3;
    localparam int SH = FRAC + 3;
    localparam int LAST = 7;
    localparam logic signed [AW-1:0] XMAX = AW'((1 <<< (XW-1)) - 1);
    localparam logic signed [AW-1:0] XMIN = AW'(-(1 <<< (XW-1)));
    localparam logic [AW-1:0] HALF = AW'(1) << (SH-1);

    typedef struct packed {
        logic                  run;
        logic [2:0]            step;
        logic [7:0][CW-1:0]    coef;
        logic [3:0][PW-1:0]    prod;
        logic [ZW-1:0]         za;
        logic [ZW-1:0]         zb;
        logic [7:0][AW-1:0]    acc;
        logic [7:0][XW-1:0]    samp;
        logic                  done;
    } state_t;

    state_t st_d, st_q;

    // multiplier array
    logic [3:0][CW-1:0] mop_w;
    logic [3:0][KW-1:0] mk_w;
    logic [3:0][PW-1:0] prod_w;

    for (genvar g = 0; g < 4; g++) begin : g_opsel
        assign mop_w[g] = st_q.coef[step_src(st_q.step, 2'(g))];
        assign mk_w[g]  = step_const(st_q.step, 2'(g));
    end

    idct8_mularray #(.CW(CW), .KW(KW), .NM(4)) u_mul (
        .op(mop_w), .kc(mk_w), .prod(prod_w)
    );

    // 4:2 compression of the registered products
    logic [3:0][ZW-1:0] pe_w;
    logic [ZW-1:0]      zsum_w, zpa_w, zpb_w;

    for (genvar g = 0; g < 4; g++) begin : g_pext
        assign pe_w[g] = {{(ZW-PW){st_q.prod[g][PW-1]}}, st_q.prod[g]};
    end

    idct8_csa42 #(.W(ZW)) u_c42 (.term(pe_w), .total(zsum_w));

    assign zpa_w = pe_w[0] + pe_w[1];
    assign zpb_w = pe_w[2] + pe_w[3];

    // pass-through entries
    logic [ZW-1:0] z0_w, z1_w;
    assign z0_w = {{(ZW-CW-FRAC){st_q.coef[0][CW-1]}}, st_q.coef[0], {FRAC{1'b0}}};
    assign z1_w = {{(ZW-CW-FRAC){st_q.coef[1][CW-1]}}, st_q.coef[1], {FRAC{1'b0}}};

    // butterfly accumulation
    logic [7:0][AW-1:0] acc_base, acc_w;
    logic [ZW-1:0]      acc_za, acc_zb;
    logic [2:0]         acc_ka, acc_kb;
    logic               acc_useb;

    always_comb begin
        acc_base = st_q.acc;
        acc_za   = st_q.za;
        acc_zb   = st_q.zb;
        acc_ka   = st_q.step + 3'd1;
        acc_kb   = 3'd3;
        acc_useb = 1'b0;
        if (st_q.step == 3'd0) begin
            acc_base = '0;
            acc_za   = z0_w;
            acc_zb   = z1_w;
            acc_ka   = 3'd0;
            acc_kb   = 3'd1;
            acc_useb = 1'b1;
        end else if (st_q.step == 3'd2) begin
            acc_ka   = 3'd2;
            acc_useb = 1'b1;
        end
    end

    idct8_acc #(.ZW(ZW), .AW(AW)) u_acc (
        .base(acc_base), .za(acc_za), .zb(acc_zb),
        .ka(acc_ka), .kb(acc_kb), .use_b(acc_useb), .nxt(acc_w)
    );

    // rounding shift and clamp
    logic [7:0][XW-1:0] sat_w;

    for (genvar n = 0; n < 8; n++) begin : g_sat
        logic signed [AW-1:0] rnd, shf;
        assign rnd = $signed(st_q.acc[n] + HALF);
        assign shf = rnd >>> SH;
        assign sat_w[n] = (shf > XMAX) ? XMAX[XW-1:0] :
                          (shf < XMIN) ? XMIN[XW-1:0] : shf[XW-1:0];
    end

    // next state
    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.run) begin
            if (start) begin
                st_d.coef = coef_in;
                st_d.run  = 1'b1;
                st_d.step = 3'd0;
            end
        end else begin
            st_d.prod = prod_w;
            st_d.step = st_q.step + 3'd1;
            if (st_q.step == 3'd1) begin
                st_d.za = zpa_w;
                st_d.zb = zpb_w;
            end else if (st_q.step >= 3'd2 && st_q.step <= 3'd5) begin
                st_d.za = zsum_w;
                st_d.zb = '0;
            end
            if (st_q.step != 3'd1 && st_q.step != 3'(LAST)) begin
                st_d.acc = acc_w;
            end
            if (st_q.step == 3'(LAST)) begin
                st_d.samp = sat_w;
                st_d.done = 1'b1;
                st_d.run  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done     = st_q.done;
    assign samp_out = st_q.samp;

    logic               busy_w;
    logic [8*CW-1:0]    coef_w;
    assign busy_w = st_q.run;
    assign coef_w = st_q.coef;

endmodule

// File: rtl/idct8_chk.sv
`timescale 1ns/1ps
module idct8_chk #(
    parameter int CW = 18,
    parameter int XW = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic [8*XW-1:0] samp,
    input logic [8*CW-1:0] coef
);
    logic [3:0] lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              lat_q <= 4'hF;
        else if (start && !busy) lat_q <= 4'd0;
        else if (busy && lat_q != 4'hF) lat_q <= lat_q + 4'd1;
    end

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == 4'd8));

    assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_hold_samples_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(samp));

    assert_ignore_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(coef));

endmodule

bind idct8_subband idct8_chk #(.CW(CW), .XW(XW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy_w),
    .done(done), .samp(samp_out), .coef(coef_w)
);

// File: tb/test_idct8_subband.sv
`timescale 1ns/1ps
module test_idct8_subband;
    localparam int CW = 18;
    localparam int XW = 12;
    localparam int NV = 12;
    localparam int WD_CYC = 200000;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            start;
    logic [8*CW-1:0] coef_in;
    logic            done;
    logic [8*XW-1:0] samp_out;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    idct8_subband #(.CW(CW), .XW(XW)) i_idct8_subband (
        .clk(clk), .rst_n(rst_n), .start(start), .coef_in(coef_in),
        .done(done), .samp_out(samp_out)
    );

    // coefficient weights of C_i inside z_j (Q14)
    localparam int ZT [0:7][0:7] = '{
        '{16384, 0, 0, 0, 0, 0, 0, 0},
        '{0, 16384, 0, 0, 0, 0, 0, 0},
        '{0, 0, 15137, -6270, 0, 0, 0, 0},
        '{0, 0, 6270, 15137, 0, 0, 0, 0},
        '{0, 0, 0, 0, 14847, -2952, -5213, 3483},
        '{0, 0, 0, 0, 6151, -1222, 12586, -8410},
        '{0, 0, 0, 0, 2952, 14847, 3483, 5213},
        '{0, 0, 0, 0, -1222, -6151, 8410, 12586}
    };

    localparam longint VEC [0:NV-1][0:7] = '{
        '{800, 0, 0, 0, 0, 0, 0, 0},
        '{0, 800, 0, 0, 0, 0, 0, 0},
        '{0, 0, 1000, 0, 0, 0, 0, 0},
        '{0, 0, 0, -1000, 0, 0, 0, 0},
        '{0, 0, 0, 0, 1000, 0, 0, 0},
        '{0, 0, 0, 0, 0, 1000, -2000, 500},
        '{1234, -567, 890, -1234, 345, -678, 901, -111},
        '{4, 0, 0, 0, 0, 0, 0, 0},
        '{-12, 0, 0, 0, 0, 0, 0, 0},
        '{131071, 0, 0, 0, 0, 0, 0, 0},
        '{-131072, 0, 0, 0, 0, 0, 0, 0},
        '{131071, 131071, 0, 0, 0, 0, 0, 0}
    };

    function automatic string vec_tag(input int v);
        case (v)
            0, 1:    return "R4";
            2, 3:    return "R5";
            4, 5:    return "R6";
            6, 7, 8: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic int sgn(input int k, input int n);
        int rk = ((k & 1) << 2) | (k & 2) | ((k >> 2) & 1);
        int pb = rk & n;
        return (((pb ^ (pb >> 1) ^ (pb >> 2)) & 1) != 0) ? -1 : 1;
    endfunction

    longint cx [8];
    longint xe [8];
    longint xa [8];

    task automatic compute_exp();
        longint z [8];
        for (int j = 0; j < 8; j++) begin
            z[j] = 0;
            for (int i = 0; i < 8; i++) z[j] += longint'(ZT[j][i]) * cx[i];
        end
        for (int n = 0; n < 8; n++) begin
            longint a = 0;
            for (int k = 0; k < 8; k++) a += sgn(k, n) * z[k];
            a = (a + 65536) >>> 17;
            if (a > 2047) a = 2047;
            if (a < -2048) a = -2048;
            xe[n] = a;
        end
    endtask

    function automatic longint samp_at(input int n);
        logic signed [XW-1:0] t;
        t = samp_out[n*XW +: XW];
        return longint'(t);
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic drive_coef();
        for (int k = 0; k < 8; k++) coef_in[k*CW +: CW] = cx[k][CW-1:0];
    endtask

    task automatic check_samples(input string tag);
        for (int n = 0; n < 8; n++) chk(tag, samp_at(n), xe[n]);
    endtask

    // start a block on the next edge and wait until its done cycle
    task automatic launch();
        @(negedge clk);
        drive_coef();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (7) @(negedge clk);
        chk("R3 early done", longint'(done), 0);
        @(negedge clk);
        chk("R3 done strobe", longint'(done), 1);
    endtask

    initial begin
        #(WD_CYC * 4);
        total++;
        bad++;
        $display("FAIL R3 watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        start   = 1'b0;
        coef_in = '0;
        repeat (3) @(negedge clk);
        chk("R1 done after reset", longint'(done), 0);
        chk("R1 samples after reset", longint'(samp_out != '0), 0);
        rst_n = 1'b1;

        // table walk
        for (int v = 0; v < NV; v++) begin
            for (int k = 0; k < 8; k++) cx[k] = VEC[v][k];
            compute_exp();
            launch();
            check_samples(vec_tag(v));
            @(negedge clk);
            chk("R3 pulse width", longint'(done), 0);
        end

        // R2 load of every field with distinct values
        cx = '{-3000, 2500, -700, 1900, -40000, 35000, -22000, 60000};
        compute_exp();
        launch();
        check_samples("R2");

        // R9: start during a running block is ignored
        cx = '{2000, -1500, 300, 700, -900, 1100, -1300, 1500};
        compute_exp();
        @(negedge clk);
        drive_coef();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 8; k++) coef_in[k*CW +: CW] = CW'(longint'(-5000 + 1234 * k));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 early done", longint'(done), 0);
        @(negedge clk);
        chk("R9 done", longint'(done), 1);
        check_samples("R9");
        begin
            int extra = 0;
            for (int c = 0; c < 10; c++) begin
                @(negedge clk);
                if (done) extra++;
            end
            chk("R9 extra done", longint'(extra), 0);
        end
        check_samples("R9 held");

        // R10: new start in the done cycle
        cx = '{-800, 400, 1200, -300, 2500, -600, 100, -2200};
        compute_exp();
        xa = xe;
        launch();
        check_samples("R10 first");
        cx = '{3000, 1000, -2000, 500, 0, 4000, -1000, 250};
        compute_exp();
        drive_coef();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        for (int n = 0; n < 8; n++) chk("R10 held", samp_at(n), xa[n]);
        repeat (3) @(negedge clk);
        chk("R10 early done", longint'(done), 0);
        @(negedge clk);
        chk("R10 second done", longint'(done), 1);
        check_samples("R10 second");

        // R11: round trip through the forward factored transform
        for (int t = 0; t < 20; t++) begin
            longint xs [8];
            longint y [8];
            for (int n = 0; n < 8; n++) xs[n] = longint'($urandom_range(3000)) - 1500;
            for (int k = 0; k < 8; k++) begin
                y[k] = 0;
                for (int n = 0; n < 8; n++) y[k] += sgn(k, n) * xs[n];
            end
            for (int i = 0; i < 8; i++) begin
                real r = 0.0;
                for (int j = 0; j < 8; j++) r += real'(ZT[j][i]) * real'(y[j]) / 16384.0;
                cx[i] = longint'(r);
            end
            launch();
            for (int n = 0; n < 8; n++) begin
                longint d = samp_at(n) - xs[n];
                total++;
                if (d > 2 || d < -2) begin
                    bad++;
                    $display("FAIL R11 act=%0d exp=%0d", samp_at(n), xs[n]);
                end
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule